// File: doc/BRIEF.md
# Priority Interrupt Controller

This block arbitrates hardware interrupt requests for a small CPU and supports nesting. Every source has a control register that holds a pending flag, an enable bit and a 4-bit priority level. A peripheral marks its request by pulsing a dedicated input. On every cycle the controller selects the strongest enabled, pending source. It raises an interrupt request toward the CPU only when that source's level is strictly above the level the CPU is running at. The request carries a vector index, and the vector index equals the source number.

When the CPU acknowledges a hardware request, the controller clears the source's flag, saves the running level on a small stack and adopts the source's level, all in the same cycle. A return-from-interrupt strobe restores the saved level. Software traps enter the same vector space: while the CPU holds a trap request, the trap number is presented as the vector ahead of any hardware source. Acknowledging a trap saves the running level and leaves it unchanged.

Software reads and writes the control registers, and reads a status word, through a simple single-cycle register bus.

Top module: `prio_intc`

## Requirements
- R1: After reset, every control register, the running level and the stack fault bit read 0, no request is raised and the vector output is 0.
- R2: Address i (i < NSRC) holds source i with the priority in bits [3:0], the enable in bit 4 and the flag in bit 5. Address NSRC is a read-only status word with the running level in bits [3:0] and the stack fault bit in bit 4. Writes to the status word have no effect. Unused bits and unmapped addresses read 0.
- R3: A pulse on a source input sets that source's flag on the next clock edge, even when a software write to that register clears the flag in the same cycle.
- R4: A source can request only when its flag and enable are both set and its priority is strictly above the running level. A source at priority 0 never requests.
- R5: Among requesting sources, the highest priority wins, and on a tie the lowest source index wins. The vector equals the winner's index. The vector is 0 when no request is raised.
- R6: An acknowledge of a hardware request clears the winner's flag, pushes the running level and loads the winner's priority as the new running level. All of this takes effect on the same clock edge.
- R7: While a service runs at level L, a pending source at level L or below does not request. A source above L does request.
- R8: While trap_req is high, irq_req is high and irq_vec equals trap_num, whatever the running level. Acknowledging a trap pushes the running level, leaves the level unchanged and clears no flag.
- R9: A return-from-interrupt pops the most recently saved level into the running level.
- R10: A return with an empty stack leaves the level unchanged and sets the stack fault bit. So does a push onto a full stack, and that push is dropped. The fault bit stays set until reset.
- R11: An acknowledge while no request is raised is ignored. When an acknowledge and a return arrive in the same cycle, the acknowledge is performed and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| src_pulse | input | NSRC | One request pulse per source |
| trap_req | input | 1 | Software trap request, held until acknowledged |
| trap_num | input | VEC_W | Trap number, used as the vector |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | VEC_W | Vector index of the request |
| irq_ack | input | 1 | CPU accepts the presented request |
| reti | input | 1 | Return from interrupt |
| cur_level | output | 4 | Running CPU priority level |
| stk_err | output | 1 | Sticky stack fault |

## Verification
A corrupted flag, enable or priority bit shows up one cycle after the write or pulse, either in the read-back word or as a wrong irq_req or irq_vec. A wrong stack entry stays hidden until the matching return. It then appears as a wrong cur_level, and often as an irq_req that should not be raised, on the cycle after that return. For this reason the bench unwinds every nesting level it builds and checks the level after each pop. An off-by-one in the stack depth shows only when the stack is pushed to its boundary, so the stack fault bit is checked there, once on the last legal push and once on the push past it.

// File: rtl/prio_intc_pkg.sv
// Shared types for the priority interrupt controller.
// Assumes a 4-bit priority field and the control word layout {flag, en, prio}.
package prio_intc_pkg;
    localparam int PRIO_W = 4;
    localparam int CTRL_W = PRIO_W + 2;

    typedef logic [PRIO_W-1:0] prio_t;

    // Packed so that {flag, en, prio} is the register image read on the bus.
    typedef struct packed {
        logic  flag;
        logic  en;
        prio_t prio;
    } src_ctrl_t;
endpackage

// File: rtl/intc_src_regs.sv
// Per-source control registers: pending flag, enable and priority.
// Assumes at most one bus write and one acknowledge clear per cycle.
// A hardware pulse overrides both a software clear and an acknowledge clear.
module intc_src_regs
    import prio_intc_pkg::*;
#(
    parameter int NSRC   = 8,
    parameter int ADDR_W = 4,
    parameter int IDX_W  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [CTRL_W-1:0]      wr_data,
    input  logic [NSRC-1:0]        hw_set,
    input  logic                   clr_en,
    input  logic [IDX_W-1:0]       clr_idx,
    output src_ctrl_t [NSRC-1:0]   ctrl
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        src_ctrl_t r;

        // Update one source: software write, then acknowledge clear, then hardware set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r <= '0;
            end else begin
                if (wr_en && wr_addr == ADDR_W'(i)) begin
                    r <= src_ctrl_t'(wr_data);
                end
                if (clr_en && clr_idx == IDX_W'(i)) begin
                    r.flag <= 1'b0;
                end
                if (hw_set[i]) begin
                    r.flag <= 1'b1;
                end
            end
        end

        assign ctrl[i] = r;
    end
endmodule

// File: rtl/intc_arbiter.sv
// Combinational winner search over all sources.
// Only flagged and enabled sources are candidates. A strict compare lets the
// lowest index keep a tie, and it excludes priority 0 because the search starts at 0.
module intc_arbiter
    import prio_intc_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int IDX_W = 3
) (
    input  src_ctrl_t [NSRC-1:0] ctrl,
    output logic                 win_valid,
    output logic [IDX_W-1:0]     win_idx,
    output prio_t                win_prio
);
    // Scan in ascending index order and keep the first strictly higher level.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (ctrl[i].flag && ctrl[i].en && ctrl[i].prio > win_prio) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_prio  = ctrl[i].prio;
            end
        end
    end
endmodule

// File: rtl/intc_level_stack.sv
// Running CPU level with a stack of saved levels and a sticky fault bit.
// A push always loads new_level. It saves the old level only when there is room.
// A pop on an empty stack keeps the level. push and pop are never both high.
module intc_level_stack
    import prio_intc_pkg::*;
#(
    parameter int STK_D = 4,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  prio_t            new_level,
    output prio_t            level,
    output logic [CNT_W-1:0] depth,
    output logic             fault
);
    localparam int PTR_W = (STK_D > 1) ? $clog2(STK_D) : 1;

    prio_t stk [STK_D];

    // Apply a push or a pop to the level, the stack and the fault bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
            depth <= '0;
            fault <= 1'b0;
            for (int i = 0; i < STK_D; i++) stk[i] <= '0;
        end else if (push) begin
            level <= new_level;
            if (depth == CNT_W'(STK_D)) begin
                fault <= 1'b1;
            end else begin
                stk[PTR_W'(depth)] <= level;
                depth <= depth + CNT_W'(1);
            end
        end else if (pop) begin
            if (depth == '0) begin
                fault <= 1'b1;
            end else begin
                level <= stk[PTR_W'(depth - CNT_W'(1))];
                depth <= depth - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/prio_intc.sv
// Top of the priority interrupt controller.
// Assumes the CPU holds trap_req until it acknowledges the trap, and pulses
// irq_ack and reti for exactly one cycle per event.
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int NSRC   = 8,
    parameter int VEC_W  = 7,
    parameter int STK_D  = 4,
    parameter int DATA_W = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bus_wr,
    input  logic [$clog2(NSRC+1)-1:0]           bus_addr,
    input  logic [DATA_W-1:0]                   bus_wdata,
    output logic [DATA_W-1:0]                   bus_rdata,
    input  logic [NSRC-1:0]                     src_pulse,
    input  logic                                trap_req,
    input  logic [VEC_W-1:0]                    trap_num,
    output logic                                irq_req,
    output logic [VEC_W-1:0]                    irq_vec,
    input  logic                                irq_ack,
    input  logic                                reti,
    output logic [3:0]                          cur_level,
    output logic                                stk_err
);
    localparam int ADDR_W = $clog2(NSRC + 1);
    localparam int IDX_W  = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam int CNT_W  = $clog2(STK_D + 1);

    src_ctrl_t [NSRC-1:0] ctrl;
    logic                 win_valid;
    logic [IDX_W-1:0]     win_idx;
    prio_t                win_prio;
    prio_t                level;
    logic [CNT_W-1:0]     stk_cnt;
    logic                 hw_req;
    logic                 take;
    logic                 hw_take;
    logic                 unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:CTRL_W];

    intc_src_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata[CTRL_W-1:0]),
        .hw_set  (src_pulse),
        .clr_en  (hw_take),
        .clr_idx (win_idx),
        .ctrl    (ctrl)
    );

    intc_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) arb_i (
        .ctrl      (ctrl),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_prio  (win_prio)
    );

    intc_level_stack #(.STK_D(STK_D), .CNT_W(CNT_W)) stk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (take),
        .pop       (reti && !take),
        .new_level (trap_req ? level : win_prio),
        .level     (level),
        .depth     (stk_cnt),
        .fault     (stk_err)
    );

    // Request qualification: a trap always requests, a source only above the level.
    always_comb begin
        hw_req  = win_valid && (win_prio > level);
        irq_req = trap_req || hw_req;
        take    = irq_ack && irq_req;
        hw_take = take && !trap_req;
        if (trap_req)    irq_vec = trap_num;
        else if (hw_req) irq_vec = VEC_W'(win_idx);
        else             irq_vec = '0;
    end

    assign cur_level = level;

    // Register read mux: source registers, then the status word, else zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr < ADDR_W'(NSRC)) begin
            bus_rdata = DATA_W'(ctrl[bus_addr[IDX_W-1:0]]);
        end else if (bus_addr == ADDR_W'(NSRC)) begin
            bus_rdata = DATA_W'({stk_err, level});
        end
    end
endmodule

// File: rtl/prio_intc_chk.sv
// Checker for the interrupt controller, bound to every prio_intc instance.
// It observes ports and the signals that join the arbiter and the level stack.
module prio_intc_chk #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_req,
    input logic             irq_ack,
    input logic             trap_req,
    input logic             reti,
    input logic [3:0]       cur_level,
    input logic             stk_err,
    input logic             win_valid,
    input logic [3:0]       win_prio,
    input logic [CNT_W-1:0] stk_cnt
);
    // R4, R7: a hardware request always comes from a source above the running level.
    p_hw_above_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !trap_req) |-> (win_valid && win_prio > cur_level));

    // R6: an accepted hardware request loads the winner's priority.
    p_ack_loads_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && !trap_req) |=> (cur_level == $past(win_prio)));

    // R8: an accepted trap keeps the running level.
    p_trap_keeps_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && trap_req) |=> $stable(cur_level));

    // R10: a return on an empty stack raises the fault and keeps the level.
    p_underflow_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !(irq_ack && irq_req) && stk_cnt == '0) |=> (stk_err && $stable(cur_level)));

    // R10: the fault bit is sticky.
    p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err |=> stk_err);

    // R11: an acknowledge with no request leaves the stack depth alone.
    p_idle_ack_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq_req && !reti) |=> $stable(stk_cnt));
endmodule

bind prio_intc prio_intc_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .irq_ack   (irq_ack),
    .trap_req  (trap_req),
    .reti      (reti),
    .cur_level (cur_level),
    .stk_err   (stk_err),
    .win_valid (win_valid),
    .win_prio  (win_prio),
    .stk_cnt   (stk_cnt)
);

// File: tb/prio_intc_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected observations, and a monitor
// compares them against the ports at the following falling edge.
module prio_intc_tb_top;
    localparam int NSRC = 8;
    localparam int VEC_W = 7;
    localparam int ADDR_W = 4;

    typedef struct {
        bit         is_rd;
        logic [7:0] exp_rd;
        logic       exp_req;
        logic [6:0] exp_vec;
        logic [3:0] exp_lvl;
        logic       exp_err;
        string      tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic [NSRC-1:0]   src_pulse = '0;
    logic              trap_req = 1'b0;
    logic [VEC_W-1:0]  trap_num = '0;
    logic              irq_req;
    logic [VEC_W-1:0]  irq_vec;
    logic              irq_ack = 1'b0;
    logic              reti = 1'b0;
    logic [3:0]        cur_level;
    logic              stk_err;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    prio_intc #(.NSRC(NSRC), .VEC_W(VEC_W), .STK_D(4), .DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_pulse(src_pulse),
        .trap_req(trap_req), .trap_num(trap_num), .irq_req(irq_req),
        .irq_vec(irq_vec), .irq_ack(irq_ack), .reti(reti),
        .cur_level(cur_level), .stk_err(stk_err)
    );

    // Monitor: pop and compare every queued expectation away from the rising edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (it.is_rd) begin
                if (bus_rdata !== it.exp_rd) begin
                    errors++;
                    $display("FAIL %s: rdata actual %02h expected %02h", it.tag, bus_rdata, it.exp_rd);
                end
            end else if (irq_req !== it.exp_req || irq_vec !== it.exp_vec ||
                         cur_level !== it.exp_lvl || stk_err !== it.exp_err) begin
                errors++;
                $display("FAIL %s: req/vec/lvl/err actual %0b/%0h/%0d/%0b expected %0b/%0h/%0d/%0b",
                         it.tag, irq_req, irq_vec, cur_level, stk_err,
                         it.exp_req, it.exp_vec, it.exp_lvl, it.exp_err);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input logic [NSRC-1:0] m);
        src_pulse = m;
        step();
        src_pulse = '0;
    endtask

    task automatic wr_pulse(input logic [ADDR_W-1:0] a, input logic [7:0] d, input logic [NSRC-1:0] m);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; src_pulse = m;
        step();
        bus_wr = 1'b0; src_pulse = '0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
    endtask

    task automatic ret();
        reti = 1'b1;
        step();
        reti = 1'b0;
    endtask

    task automatic exp_state(input logic r, input logic [6:0] v, input logic [3:0] l,
                             input logic e, input string tag);
        item_t it;
        it.is_rd = 1'b0; it.exp_rd = '0; it.exp_req = r; it.exp_vec = v;
        it.exp_lvl = l; it.exp_err = e; it.tag = tag;
        sb_q.push_back(it);
        step();
    endtask

    task automatic exp_rd(input logic [ADDR_W-1:0] a, input logic [7:0] d, input string tag);
        item_t it;
        bus_addr = a;
        it.is_rd = 1'b1; it.exp_rd = d; it.exp_req = 1'b0; it.exp_vec = '0;
        it.exp_lvl = '0; it.exp_err = 1'b0; it.tag = tag;
        sb_q.push_back(it);
        step();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    // Driver: stimulus sequence with expected values worked out from the requirements.
    initial begin
        #1;
        do_reset();
        exp_state(0, 7'h00, 0, 0, "R1 idle after reset");
        exp_rd(0, 8'h00, "R1 source 0 cleared");
        exp_rd(8, 8'h00, "R1 status cleared");

        wr(2, 8'h1A);
        exp_rd(2, 8'h1A, "R2 source 2 read back");
        wr(3, 8'hC5);
        exp_rd(3, 8'h05, "R2 unused bits read 0");
        wr(8, 8'hFF);
        exp_rd(8, 8'h00, "R2 status not writable");
        exp_rd(15, 8'h00, "R2 unmapped address");

        pulse(8'b0000_1000);
        exp_rd(3, 8'h25, "R3 pulse sets flag");
        exp_state(0, 7'h00, 0, 0, "R4 disabled source silent");
        wr(4, 8'h30);
        exp_state(0, 7'h00, 0, 0, "R4 priority 0 never requests");
        wr(3, 8'h35);
        exp_state(1, 7'h03, 0, 0, "R4 enabled source requests");

        pulse(8'b0000_0100);
        exp_state(1, 7'h02, 0, 0, "R5 higher priority wins");
        wr(6, 8'h3A);
        exp_state(1, 7'h02, 0, 0, "R5 tie lowest index");

        ack();
        exp_state(0, 7'h00, 10, 0, "R6 R7 ack loads level 10");
        exp_rd(2, 8'h1A, "R6 ack clears flag");
        wr(5, 8'h3B);
        exp_state(1, 7'h05, 10, 0, "R7 higher level preempts");
        ack();
        exp_state(0, 7'h00, 11, 0, "R6 nested level 11");

        trap_req = 1'b1; trap_num = 7'h55;
        exp_state(1, 7'h55, 11, 0, "R8 trap vector");
        ack();
        exp_state(1, 7'h55, 11, 0, "R8 trap ack keeps level");
        exp_rd(6, 8'h3A, "R8 trap clears no flag");
        trap_req = 1'b0;

        ret();
        exp_state(0, 7'h00, 11, 0, "R9 pop after trap");
        ret();
        exp_state(0, 7'h00, 10, 0, "R9 pop to 10");
        ret();
        exp_state(1, 7'h06, 0, 0, "R9 pop to 0 reveals source 6");
        ret();
        exp_state(1, 7'h06, 0, 1, "R10 underflow sets fault");
        exp_rd(8, 8'h10, "R10 status shows fault");

        wr(6, 8'h1A);
        wr(3, 8'h15);
        exp_state(0, 7'h00, 0, 1, "R11 no request pending");
        ack();
        exp_state(0, 7'h00, 0, 1, "R11 idle ack ignored");

        wr_pulse(3, 8'h15, 8'b0000_1000);
        exp_rd(3, 8'h35, "R3 pulse beats software clear");
        exp_state(1, 7'h03, 0, 1, "R3 source 3 requests");
        irq_ack = 1'b1; reti = 1'b1;
        step();
        irq_ack = 1'b0; reti = 1'b0;
        exp_state(0, 7'h00, 5, 1, "R11 ack beats reti");
        ret();
        exp_state(0, 7'h00, 0, 1, "R9 pop after ack plus reti");

        do_reset();
        exp_rd(3, 8'h00, "R1 second reset clears source");
        exp_state(0, 7'h00, 0, 0, "R1 second reset clears fault");

        trap_req = 1'b1; trap_num = 7'h12;
        exp_state(1, 7'h12, 0, 0, "R8 trap at level 0");
        for (int k = 0; k < 4; k++) ack();
        exp_state(1, 7'h12, 0, 0, "R10 full stack no fault");
        ack();
        exp_state(1, 7'h12, 0, 1, "R10 overflow sets fault");
        trap_req = 1'b0;
        step();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule